// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block joins two 8-bit buses, called A and B, and can move data between them in either direction. Each direction owns a storage register. The A-side register samples the A input on the rising edge of its own capture clock, and the B-side register samples the B input on the rising edge of a second, independent capture clock. An active-low asynchronous reset clears both registers.

An active-low output enable and a direction input decide which bus the block drives, if any. For the bus being driven, a per-direction select picks the source. The source is either the live value of the opposite bus or that direction's stored register. The paths never invert data. Each bus is modelled as separate input, output and output-enable signals, so the block can sit inside a synchronous design. The pad or tri-state logic that merges these signals lives outside the block.

Register capture never depends on the enable or the direction. Data can therefore be stored while the block is isolated from both buses, and a bus the block is driving can still be sampled into its own register.

Top module: `xcvr_bus_link`

## Requirements
- R1: While rst_n is low, both stored registers read 0. After reset, selecting stored data on either bus drives 0x00.
- R2: On every rising edge of clk_ab, the A-to-B register loads a_in. It holds its value across edges of clk_ba and across changes of a_in between edges.
- R3: On every rising edge of clk_ba, the B-to-A register loads b_in. It holds its value across edges of clk_ab and across changes of b_in between edges.
- R4: With out_en_n = 1, both a_oe and b_oe are 0, whatever the direction and select inputs are.
- R5: With out_en_n = 0, dir_to_b = 1 sets b_oe = 1 and a_oe = 0, and dir_to_b = 0 sets a_oe = 1 and b_oe = 0.
- R6: When B is driven, sel_ab_store = 0 puts the live a_in on b_out, and sel_ab_store = 1 puts the stored A-to-B register on b_out. Both paths are bit-for-bit non-inverting.
- R7: When A is driven, sel_ba_store = 0 puts the live b_in on a_out, and sel_ba_store = 1 puts the stored B-to-A register on a_out.
- R8: Captures on both clocks still take effect while out_en_n = 1 (isolation).
- R9: A bus that the block is driving can still be captured into its own register. Sampling a_in while A is driven loads the A-to-B register.
- R10: a_oe and b_oe are never 1 at the same time.
- R11: An output whose enable is 0 reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ab | input | 1 | Capture clock for the A-to-B register |
| clk_ba | input | 1 | Capture clock for the B-to-A register |
| rst_n | input | 1 | Asynchronous active-low reset of both registers |
| out_en_n | input | 1 | Active-low output enable; 1 isolates both buses |
| dir_to_b | input | 1 | 1 drives bus B, 0 drives bus A |
| sel_ab_store | input | 1 | Source for bus B: 0 live A, 1 stored A-to-B register |
| sel_ba_store | input | 1 | Source for bus A: 0 live B, 1 stored B-to-A register |
| a_in | input | 8 | Value seen on bus A |
| a_out | output | 8 | Value the block drives onto bus A |
| a_oe | output | 1 | Drive enable for bus A |
| b_in | input | 8 | Value seen on bus B |
| b_out | output | 8 | Value the block drives onto bus B |
| b_oe | output | 1 | Drive enable for bus B |

## Verification
Two functions can fall in the same cycle here: a register capture and the drive of the bus that the register feeds in stored mode. The bench provokes this by holding B driven with sel_ab_store = 1 while it pulses clk_ab with a new a_in. It checks that b_out shows the old stored value just before the edge and the new value just after it. The bench also fires both capture clocks together and confirms that each register takes only its own bus.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  // Which bus the block is currently driving.
  typedef enum logic [1:0] {
    DRV_NONE = 2'd0,
    DRV_TO_A = 2'd1,
    DRV_TO_B = 2'd2
  } drive_e;
endpackage

// File: rtl/xcvr_capture_reg.sv
module xcvr_capture_reg #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q     <= '0;
      armed <= 1'b0;
    end else begin
      q     <= d;
      armed <= 1'b1;
    end
  end

  // Once an edge has passed since reset, the stored value equals the input sampled at the previous edge.
  p_capture_r2_r3: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> (q == $past(d)));
endmodule

// File: rtl/xcvr_drive_ctl.sv
module xcvr_drive_ctl
  import xcvr_pkg::*;
(
  input  logic   rst_n,
  input  logic   out_en_n,
  input  logic   dir_to_b,
  output drive_e drive,
  output logic   a_oe,
  output logic   b_oe
);
  always_comb begin
    if (out_en_n)      drive = DRV_NONE;
    else if (dir_to_b) drive = DRV_TO_B;
    else               drive = DRV_TO_A;
  end

  assign a_oe = (drive == DRV_TO_A);
  assign b_oe = (drive == DRV_TO_B);

  always_comb begin
    if (rst_n) begin
      p_single_drive_r10: assert (!(a_oe && b_oe));
      if (out_en_n) begin
        p_isolate_r4: assert (!a_oe && !b_oe);
      end
    end
  end
endmodule

// File: rtl/xcvr_path_mux.sv
module xcvr_path_mux #(
  parameter int WIDTH = 8
) (
  input  logic             oe,
  input  logic             use_store,
  input  logic [WIDTH-1:0] live,
  input  logic [WIDTH-1:0] stored,
  output logic [WIDTH-1:0] y
);
  logic [WIDTH-1:0] picked;

  // One selector per bit keeps every path non-inverting.
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign picked[i] = use_store ? stored[i] : live[i];
  end

  assign y = oe ? picked : '0;
endmodule

// File: rtl/xcvr_bus_link.sv
module xcvr_bus_link
  import xcvr_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk_ab,
  input  logic             clk_ba,
  input  logic             rst_n,
  input  logic             out_en_n,
  input  logic             dir_to_b,
  input  logic             sel_ab_store,
  input  logic             sel_ba_store,
  input  logic [WIDTH-1:0] a_in,
  output logic [WIDTH-1:0] a_out,
  output logic             a_oe,
  input  logic [WIDTH-1:0] b_in,
  output logic [WIDTH-1:0] b_out,
  output logic             b_oe
);
  logic [WIDTH-1:0] store_ab;
  logic [WIDTH-1:0] store_ba;
  drive_e           drive;

  // Captures run whatever the enable and direction are.
  xcvr_capture_reg #(.WIDTH(WIDTH)) u_reg_ab (
    .clk(clk_ab), .rst_n(rst_n), .d(a_in), .q(store_ab)
  );

  xcvr_capture_reg #(.WIDTH(WIDTH)) u_reg_ba (
    .clk(clk_ba), .rst_n(rst_n), .d(b_in), .q(store_ba)
  );

  xcvr_drive_ctl u_ctl (
    .rst_n(rst_n), .out_en_n(out_en_n), .dir_to_b(dir_to_b),
    .drive(drive), .a_oe(a_oe), .b_oe(b_oe)
  );

  xcvr_path_mux #(.WIDTH(WIDTH)) u_mux_to_b (
    .oe(b_oe), .use_store(sel_ab_store), .live(a_in),
    .stored(store_ab), .y(b_out)
  );

  xcvr_path_mux #(.WIDTH(WIDTH)) u_mux_to_a (
    .oe(a_oe), .use_store(sel_ba_store), .live(b_in),
    .stored(store_ba), .y(a_out)
  );

  always_comb begin
    if (rst_n) begin
      if (b_oe && !sel_ab_store) begin
        p_live_to_b_r6: assert (b_out == a_in);
      end
      if (a_oe && !sel_ba_store) begin
        p_live_to_a_r7: assert (a_out == b_in);
      end
      if (!a_oe) begin
        p_quiet_a_r11: assert (a_out == '0);
      end
      if (!b_oe) begin
        p_quiet_b_r11: assert (b_out == '0);
      end
      if (drive == DRV_NONE) begin
        p_none_r4: assert (!out_en_n == 1'b0);
      end
    end
  end
endmodule

// File: tb/sim_xcvr_bus_link.sv
`timescale 1ns/1ps
module sim_xcvr_bus_link;
  logic       clk = 1'b0;
  logic       clk_ab = 1'b0, clk_ba = 1'b0, rst_n = 1'b0;
  logic       out_en_n = 1'b1, dir_to_b = 1'b0;
  logic       sel_ab_store = 1'b0, sel_ba_store = 1'b0;
  logic [7:0] a_in = 8'h00, b_in = 8'h00;
  logic [7:0] a_out, b_out;
  logic       a_oe, b_oe;
  int         n_chk = 0, n_bad = 0;
  logic [7:0] exp_ab = 8'h00, exp_ba = 8'h00;

  always #10 clk = ~clk; // 50 MHz

  xcvr_bus_link u0 (
    .clk_ab(clk_ab), .clk_ba(clk_ba), .rst_n(rst_n), .out_en_n(out_en_n),
    .dir_to_b(dir_to_b), .sel_ab_store(sel_ab_store), .sel_ba_store(sel_ba_store),
    .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
    .b_in(b_in), .b_out(b_out), .b_oe(b_oe)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic pulse_ab();
    @(negedge clk); clk_ab = 1'b1; exp_ab = a_in; #5; clk_ab = 1'b0; #5;
  endtask

  task automatic pulse_ba();
    @(negedge clk); clk_ba = 1'b1; exp_ba = b_in; #5; clk_ba = 1'b0; #5;
  endtask

  task automatic set_ctl(input logic en_n, input logic dir, input logic sab, input logic sba);
    out_en_n = en_n; dir_to_b = dir; sel_ab_store = sab; sel_ba_store = sba; #2;
  endtask

  task automatic t_reset();
    set_ctl(0, 1, 1, 1);
    chk("R1 stored A-to-B after reset", b_out, 8'h00);
    set_ctl(0, 0, 1, 1);
    chk("R1 stored B-to-A after reset", a_out, 8'h00);
  endtask

  task automatic t_enable_matrix();
    for (int m = 0; m < 16; m++) begin
      set_ctl(m[0], m[1], m[2], m[3]);
      chk("R4/R5/R10 a_oe", {7'd0, a_oe}, {7'd0, !m[0] && !m[1]});
      chk("R4/R5/R10 b_oe", {7'd0, b_oe}, {7'd0, !m[0] && m[1]});
      if (!a_oe) chk("R11 idle a_out", a_out, 8'h00);
      if (!b_oe) chk("R11 idle b_out", b_out, 8'h00);
    end
  endtask

  task automatic t_ab_path();
    a_in = 8'h5A; pulse_ab();
    a_in = 8'h33; set_ctl(0, 1, 1, 0);
    chk("R2/R6 stored to B", b_out, exp_ab);
    set_ctl(0, 1, 0, 0);
    chk("R6 live to B", b_out, 8'h33);
    b_in = 8'hE1; pulse_ba(); set_ctl(0, 1, 1, 0);
    chk("R2 hold across clk_ba", b_out, 8'h5A);
  endtask

  task automatic t_ba_path();
    b_in = 8'hA7; pulse_ba();
    b_in = 8'h0F; set_ctl(0, 0, 0, 1);
    chk("R3/R7 stored to A", a_out, exp_ba);
    set_ctl(0, 0, 0, 0);
    chk("R7 live to A", a_out, 8'h0F);
    a_in = 8'h11; pulse_ab(); set_ctl(0, 0, 0, 1);
    chk("R3 hold across clk_ab", a_out, 8'hA7);
  endtask

  task automatic t_isolation_capture();
    set_ctl(1, 0, 0, 0);
    a_in = 8'hC3; b_in = 8'h3C; pulse_ab(); pulse_ba();
    set_ctl(0, 1, 1, 1);
    chk("R8 isolated capture A", b_out, 8'hC3);
    set_ctl(0, 0, 1, 1);
    chk("R8 isolated capture B", a_out, 8'h3C);
  endtask

  task automatic t_driven_capture();
    set_ctl(0, 0, 0, 0);
    a_in = 8'h96; pulse_ab();
    chk("R9 A still driven", {7'd0, a_oe}, 8'h01);
    set_ctl(0, 1, 1, 0);
    chk("R9 driven bus captured", b_out, 8'h96);
  endtask

  task automatic t_same_cycle();
    set_ctl(0, 1, 1, 0);
    a_in = 8'h4D;
    @(negedge clk); #1;
    chk("R6 old stored before edge", b_out, 8'h96);
    clk_ab = 1'b1; #2;
    chk("R2 new stored after edge", b_out, 8'h4D);
    #3; clk_ab = 1'b0;
    a_in = 8'hF0; b_in = 8'h0A;
    @(negedge clk); clk_ab = 1'b1; clk_ba = 1'b1; #5; clk_ab = 1'b0; clk_ba = 1'b0; #2;
    chk("R2 joint edge A", b_out, 8'hF0);
    set_ctl(0, 0, 0, 1);
    chk("R3 joint edge B", a_out, 8'h0A);
  endtask

  initial begin
    #50;
    chk("R1 a_oe in reset", {7'd0, a_oe}, 8'h00);
    rst_n = 1'b1; #5;
    t_reset();
    t_enable_matrix();
    t_ab_path();
    t_ba_path();
    t_isolation_capture();
    t_driven_capture();
    t_same_cycle();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule